// File: doc/BRIEF.md
# Reservation Station Handshake Sequencer

This block lets several issuing ports share one pipelined ALU. Every side uses valid/ready handshakes. Each port runs its own four-phase sequence: take in an operand packet, hand it to the ALU, wait for the result that carries the port's tag, then deliver that result on the port's output channel. A port holds at most one packet in flight.

Both handoffs skip the wait phase when the far side is already ready. If the ALU takes the request in the cycle the packet is accepted, the operand goes straight through without being stored. If the port's output is ready in the cycle the result returns, the result goes straight out without being stored. When the far side is not ready, the data is latched into the port's single holding register and presented from there until it is taken. With both skips taken, a packet passes through in two cycles.

Several ports can want the ALU input in the same cycle. A fixed priority picker then grants the lowest index. Each request carries the index of the issuing port as a tag. The ALU returns the tag with the result, and the block uses it to steer the result back to the right port.

Top module: `rs_station`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts every port in its accept phase: all `in_ready` bits high, all `out_valid` bits low and `alu_req_valid` low.
- R2: A port in its accept phase with `in_valid` high requests the ALU in that same cycle. If it wins arbitration and `alu_req_ready` is high, `alu_req_data` equals that port's `in_data` in that cycle and the packet enters the ALU with no further wait.
- R3: A packet that is accepted while its request is not taken is latched. From the next cycle on, the port keeps requesting with the latched operand, unchanged, until the request is taken, even if `in_data` changes meanwhile.
- R4: `in_ready` of a port is high only in its accept phase. It goes low in the cycle after an input handshake and stays low until that port's result has been accepted on its output.
- R5: When a result tagged for a port that is waiting for it arrives and that port's `out_ready` is high, `out_valid` rises in the same cycle with `out_data` equal to `alu_rsp_data`. The port returns to its accept phase at the next edge.
- R6: When such a result arrives while `out_ready` is low, the result is latched. `out_valid` stays high with `out_data` unchanged on every following cycle until `out_ready` is high.
- R7: With the ALU ready at acceptance, a one-cycle ALU and the output ready, a packet's output handshake occurs in the second cycle, counting the input handshake cycle as the first.
- R8: When several ports request the ALU in one cycle, the lowest port index is granted and appears on `alu_req_tag`. The others keep requesting in later cycles.
- R9: `alu_req_tag` is the index of the granted port. A result with `alu_rsp_tag` equal to p raises `out_valid` only on port p.
- R10: Every accepted packet is delivered exactly once, on its own port, as the ALU's result for that packet's operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | NPORT | Per-port operand valid |
| in_ready | output | NPORT | Per-port operand ready (high in accept phase) |
| in_data | input | NPORT*DW | Per-port operand, port p in bits p*DW +: DW |
| out_valid | output | NPORT | Per-port result valid |
| out_ready | input | NPORT | Per-port result ready |
| out_data | output | NPORT*DW | Per-port result, port p in bits p*DW +: DW |
| alu_req_valid | output | 1 | Request to the shared ALU is valid |
| alu_req_ready | input | 1 | ALU can take a request this cycle |
| alu_req_data | output | DW | Operand sent to the ALU |
| alu_req_tag | output | TAG_W | Index of the port issuing the request |
| alu_rsp_valid | input | 1 | ALU result valid |
| alu_rsp_data | input | DW | ALU result |
| alu_rsp_tag | input | TAG_W | Port index returned with the result |

## Verification
A lone packet on one port with every far side ready shows the fully skipped two-cycle path. It is followed by a packet that meets a stalled ALU and a packet that meets a stalled output, which separate the latched paths from the pass-through paths and show that latched values stay unchanged. All ports firing in the same cycle show the lowest-index-first order in which issues are granted. A long stretch of random valids, operands and readies on both far sides then compares every output against a behavioural phase model on each cycle. A per-port scoreboard confirms that each accepted operand comes back exactly once, transformed by the bench's ALU, on the port that sent it.

// File: rtl/rs_pkg.sv
package rs_pkg;

    // Phase of one port's handshake sequence.
    typedef enum logic [1:0] {
        PH_ACCEPT  = 2'd0,  // waiting for an operand packet
        PH_ISSUE   = 2'd1,  // operand latched, still requesting the ALU
        PH_AWAIT   = 2'd2,  // request taken, waiting for the tagged result
        PH_DELIVER = 2'd3   // result latched, presenting it on the output
    } rs_phase_e;

endpackage

// File: rtl/rs_prio_pick.sv
module rs_prio_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic          any,
    output logic [IW-1:0] idx
);

    // Lowest index wins: scan downwards so the last hit is the smallest.
    always_comb begin
        gnt = '0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = i[IW-1:0];
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/rs_port_fsm.sv
module rs_port_fsm
    import rs_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    // operand side
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    // ALU request side
    output logic          req_valid,
    output logic [DW-1:0] req_data,
    input  logic          grant,
    // ALU result side
    input  logic          rsp_hit,
    input  logic [DW-1:0] rsp_data,
    // result side
    input  logic          out_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);

    typedef struct packed {
        rs_phase_e     phase;
        logic [DW-1:0] hold;
    } port_st_t;

    port_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_ACCEPT: begin
                if (in_valid) begin
                    if (grant) begin
                        st_d.phase = PH_AWAIT;
                    end else begin
                        st_d.phase = PH_ISSUE;
                        st_d.hold  = in_data;
                    end
                end
            end
            PH_ISSUE: begin
                if (grant) begin
                    st_d.phase = PH_AWAIT;
                end
            end
            PH_AWAIT: begin
                if (rsp_hit) begin
                    if (out_ready) begin
                        st_d.phase = PH_ACCEPT;
                    end else begin
                        st_d.phase = PH_DELIVER;
                        st_d.hold  = rsp_data;
                    end
                end
            end
            PH_DELIVER: begin
                if (out_ready) begin
                    st_d.phase = PH_ACCEPT;
                end
            end
            default: st_d.phase = PH_ACCEPT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{phase: PH_ACCEPT, hold: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = (st_q.phase == PH_ACCEPT);
    assign req_valid = ((st_q.phase == PH_ACCEPT) && in_valid) || (st_q.phase == PH_ISSUE);
    assign req_data  = (st_q.phase == PH_ACCEPT) ? in_data : st_q.hold;
    assign out_valid = ((st_q.phase == PH_AWAIT) && rsp_hit) || (st_q.phase == PH_DELIVER);
    assign out_data  = (st_q.phase == PH_DELIVER) ? st_q.hold : rsp_data;

endmodule

// File: rtl/rs_station.sv
module rs_station #(
    parameter int NPORT = 4,
    parameter int DW    = 16,
    parameter int TAG_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NPORT-1:0]    in_valid,
    output logic [NPORT-1:0]    in_ready,
    input  logic [NPORT*DW-1:0] in_data,
    output logic [NPORT-1:0]    out_valid,
    input  logic [NPORT-1:0]    out_ready,
    output logic [NPORT*DW-1:0] out_data,
    output logic                alu_req_valid,
    input  logic                alu_req_ready,
    output logic [DW-1:0]       alu_req_data,
    output logic [TAG_W-1:0]    alu_req_tag,
    input  logic                alu_rsp_valid,
    input  logic [DW-1:0]       alu_rsp_data,
    input  logic [TAG_W-1:0]    alu_rsp_tag
);

    logic [NPORT-1:0] port_req;
    logic [NPORT-1:0] port_gnt;
    logic [NPORT-1:0] port_hit;
    logic [DW-1:0]    port_req_data [NPORT];

    rs_prio_pick #(
        .N  (NPORT),
        .IW (TAG_W)
    ) u_pick (
        .req (port_req),
        .gnt (port_gnt),
        .any (alu_req_valid),
        .idx (alu_req_tag)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign port_hit[p] = alu_rsp_valid && (alu_rsp_tag == TAG_W'(p));

        rs_port_fsm #(
            .DW (DW)
        ) u_port (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (in_valid[p]),
            .in_data   (in_data[p*DW +: DW]),
            .in_ready  (in_ready[p]),
            .req_valid (port_req[p]),
            .req_data  (port_req_data[p]),
            .grant     (port_gnt[p] && alu_req_ready),
            .rsp_hit   (port_hit[p]),
            .rsp_data  (alu_rsp_data),
            .out_ready (out_ready[p]),
            .out_valid (out_valid[p]),
            .out_data  (out_data[p*DW +: DW])
        );
    end

    // One-hot grant selects the operand that goes to the ALU.
    always_comb begin
        alu_req_data = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (port_gnt[p]) begin
                alu_req_data = alu_req_data | port_req_data[p];
            end
        end
    end

endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk #(
    parameter int NPORT = 4,
    parameter int DW    = 16,
    parameter int TAG_W = 2
) (
    input logic                clk,
    input logic                rst,
    input logic [NPORT-1:0]    in_valid,
    input logic [NPORT-1:0]    in_ready,
    input logic [NPORT-1:0]    out_valid,
    input logic [NPORT-1:0]    out_ready,
    input logic [NPORT*DW-1:0] out_data,
    input logic                alu_req_valid,
    input logic                alu_req_ready,
    input logic [TAG_W-1:0]    alu_req_tag
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ((&in_ready) && (out_valid == '0) && !alu_req_valid));

    // R3
    stall_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_req_valid && !alu_req_ready) |=> alu_req_valid);

    // R8
    tag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_req_valid && !alu_req_ready && (alu_req_tag == '0)) |=>
            (alu_req_valid && (alu_req_tag == '0)));

    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        // R4
        accept_block_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid[p] && in_ready[p]) |=> !in_ready[p]);

        // R6
        result_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (out_valid[p] && !out_ready[p]) |=>
                (out_valid[p] && $stable(out_data[p*DW +: DW])));

        // R5
        release_chk: assert property (@(posedge clk) disable iff (rst)
            (out_valid[p] && out_ready[p]) |=> in_ready[p]);

        // R4
        busy_no_valid_out_chk: assert property (@(posedge clk) disable iff (rst)
            in_ready[p] |-> !out_valid[p]);
    end

endmodule

bind rs_station rs_station_chk #(
    .NPORT (NPORT),
    .DW    (DW),
    .TAG_W (TAG_W)
) u_rs_station_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data      (out_data),
    .alu_req_valid (alu_req_valid),
    .alu_req_ready (alu_req_ready),
    .alu_req_tag   (alu_req_tag)
);

// File: tb/rs_station_bench.sv
module rs_station_bench;

    localparam int NPORT = 4;
    localparam int DW    = 16;
    localparam int TAG_W = 2;

    // 50 MHz: period of 20 time units (ns)
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                rst;
    logic [NPORT-1:0]    in_valid, in_ready, out_valid, out_ready;
    logic [NPORT*DW-1:0] in_data, out_data;
    logic                alu_req_valid, alu_req_ready, alu_rsp_valid;
    logic [DW-1:0]       alu_req_data, alu_rsp_data;
    logic [TAG_W-1:0]    alu_req_tag, alu_rsp_tag;

    rs_station #(.NPORT(NPORT), .DW(DW), .TAG_W(TAG_W)) u_rs_station (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .alu_req_valid(alu_req_valid), .alu_req_ready(alu_req_ready),
        .alu_req_data(alu_req_data), .alu_req_tag(alu_req_tag),
        .alu_rsp_valid(alu_rsp_valid), .alu_rsp_data(alu_rsp_data),
        .alu_rsp_tag(alu_rsp_tag)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // behavioural model: phase 0 accept, 1 issue, 2 await, 3 deliver
    int            ph       [NPORT];
    logic [DW-1:0] hold     [NPORT];
    logic [DW-1:0] want     [NPORT];
    int            acc_cyc  [NPORT];
    int            last_lat [NPORT];
    int            cyc, n_acc, n_del;
    int            issue_log[$];

    // bench ALU, one-cycle latency
    logic             apv;
    logic [TAG_W-1:0] apt;
    logic [DW-1:0]    apd;

    // stimulus
    logic [NPORT-1:0]    s_iv, s_or;
    logic                s_ar;
    logic [NPORT*DW-1:0] s_id;

    function automatic logic [DW-1:0] alu_fn(input logic [DW-1:0] x);
        return DW'(x * 3 + 16'h1357);
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    task automatic step();
        int win;
        logic [NPORT-1:0] e_ready, e_ov;
        logic [DW-1:0] edat;
        @(negedge clk);
        alu_rsp_valid = apv;
        alu_rsp_tag   = apt;
        alu_rsp_data  = apd;
        in_valid      = s_iv;
        in_data       = s_id;
        out_ready     = s_or;
        alu_req_ready = s_ar;
        #2;
        win = -1;
        for (int p = 0; p < NPORT; p++) begin
            e_ready[p] = (ph[p] == 0);
            if (((ph[p] == 0 && in_valid[p]) || ph[p] == 1) && win < 0) win = p;
            e_ov[p] = (ph[p] == 2 && alu_rsp_valid && alu_rsp_tag == TAG_W'(p)) || ph[p] == 3;
        end
        chk(in_ready == e_ready, "R4", 64'(in_ready), 64'(e_ready));
        chk(alu_req_valid == (win >= 0), "R2", 64'(alu_req_valid), 64'(win >= 0));
        if (win >= 0) begin
            chk(alu_req_tag == TAG_W'(win), "R8", 64'(alu_req_tag), 64'(win));
            edat = (ph[win] == 0) ? in_data[win*DW +: DW] : hold[win];
            chk(alu_req_data == edat, (ph[win] == 0) ? "R2" : "R3", 64'(alu_req_data), 64'(edat));
        end
        chk(out_valid == e_ov, "R9", 64'(out_valid), 64'(e_ov));
        for (int p = 0; p < NPORT; p++) begin
            if (e_ov[p]) begin
                edat = (ph[p] == 3) ? hold[p] : alu_rsp_data;
                chk(out_data[p*DW +: DW] == edat, (ph[p] == 3) ? "R6" : "R5",
                    64'(out_data[p*DW +: DW]), 64'(edat));
                if (out_ready[p]) begin
                    chk(out_data[p*DW +: DW] == want[p], "R10", 64'(out_data[p*DW +: DW]), 64'(want[p]));
                    n_del++;
                    last_lat[p] = cyc - acc_cyc[p] + 1;
                end
            end
        end
        // advance the model
        for (int p = 0; p < NPORT; p++) begin
            case (ph[p])
                0: if (in_valid[p]) begin
                       n_acc++;
                       want[p]    = alu_fn(in_data[p*DW +: DW]);
                       acc_cyc[p] = cyc;
                       if (win == p && alu_req_ready) ph[p] = 2;
                       else begin ph[p] = 1; hold[p] = in_data[p*DW +: DW]; end
                   end
                1: if (win == p && alu_req_ready) ph[p] = 2;
                2: if (alu_rsp_valid && alu_rsp_tag == TAG_W'(p)) begin
                       if (out_ready[p]) ph[p] = 0;
                       else begin ph[p] = 3; hold[p] = alu_rsp_data; end
                   end
                default: if (out_ready[p]) ph[p] = 0;
            endcase
        end
        apv = alu_req_valid && alu_req_ready;
        apt = alu_req_tag;
        apd = alu_fn(alu_req_data);
        if (apv) issue_log.push_back(int'(alu_req_tag));
        cyc++;
    endtask

    initial begin
        #(64'd200000 * 20);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        in_valid = '0; in_data = '0; out_ready = '0; alu_req_ready = 1'b0;
        alu_rsp_valid = 1'b0; alu_rsp_data = '0; alu_rsp_tag = '0;
        apv = 1'b0; apt = '0; apd = '0;
        cyc = 0; n_acc = 0; n_del = 0;
        for (int p = 0; p < NPORT; p++) begin
            ph[p] = 0; hold[p] = '0; want[p] = '0; acc_cyc[p] = 0; last_lat[p] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        // R1: reset state
        chk(in_ready == '1 && out_valid == '0 && !alu_req_valid, "R1",
            64'({in_ready, out_valid, alu_req_valid}), 64'({4'hF, 4'h0, 1'b0}));

        s_iv = '0; s_or = '1; s_ar = 1'b1; s_id = '0;

        // R7: single packet, all far sides ready
        s_iv = 4'b0100; s_id[2*DW +: DW] = 16'h1234;
        step();
        s_iv = '0;
        repeat (3) step();
        chk(last_lat[2] == 2, "R7", 64'(last_lat[2]), 64'd2);

        // R3: ALU stalled at acceptance, operand changes underneath
        s_ar = 1'b0; s_iv = 4'b0001; s_id[0 +: DW] = 16'hA0A0;
        step();
        s_iv = '0; s_id[0 +: DW] = 16'h5F5F;
        repeat (3) step();
        s_ar = 1'b1;
        repeat (3) step();
        chk(last_lat[0] == 6, "R3", 64'(last_lat[0]), 64'd6);

        // R6: output stalled when the result returns
        s_or = 4'b1101; s_iv = 4'b0010; s_id[DW +: DW] = 16'h0F0F;
        step();
        s_iv = '0;
        repeat (4) step();
        s_or = '1;
        repeat (2) step();
        chk(last_lat[1] == 6, "R6", 64'(last_lat[1]), 64'd6);

        // R8: all ports at once
        issue_log.delete();
        s_iv = '1; s_id = 64'h4444_3333_2222_1111;
        step();
        s_iv = '0;
        repeat (8) step();
        chk(issue_log.size() == 4, "R8", 64'(issue_log.size()), 64'd4);
        for (int i = 0; i < 4 && i < issue_log.size(); i++)
            chk(issue_log[i] == i, "R8", 64'(issue_log[i]), 64'(i));

        // random traffic with random far-side stalls
        for (int n = 0; n < 3000; n++) begin
            s_iv = NPORT'($urandom);
            s_id = {$urandom, $urandom};
            s_or = NPORT'($urandom | $urandom);
            s_ar = ($urandom_range(0, 3) != 0);
            step();
        end

        // drain
        s_iv = '0; s_or = '1; s_ar = 1'b1;
        repeat (20) step();
        chk(n_acc == n_del, "R10", 64'(n_del), 64'(n_acc));
        chk(n_acc > 100, "R10", 64'(n_acc), 64'd101);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule